// File: doc/BRIEF.md
# Delayed-LMS Coefficient Update Array

This block holds the N coefficients of a delayed-LMS adaptive filter and renews all of them on each accepted sample. For every tap, the block takes a delayed error value and the matching delayed input sample. It scales the error by a step size that is a negative power of two, multiplies it by the sample, and adds the product to the stored coefficient. The result saturates to the coefficient range. The renewed coefficients leave the block on a flat output bus. They go to the filter datapath and also return internally to serve as the old values for the next update.

The multipliers work in radix 4. Each sample is cut into two-bit digits, and each digit selects a ready-made multiple of the scaled error. The lower digits select zero, one, two or three times the scaled error. The top digit is signed and selects zero, plus one, minus two or minus one times the scaled error. The triple multiple and the negated multiples are formed once and shared by every lane. There are two pipeline stages. The first registers the error and the taps. The second sits inside each lane's shift-add tree, between the lower-digit and upper-digit partial sums and their final addition. The coefficient register then closes the loop.

Top module: `dlms_wupd_array`

## Requirements
- R1: While `rst_n` is low, every coefficient on `wts_out` is zero, and the pipeline holds no pending update.
- R2: An accepted update changes lane i to w_i + s*x_i, where s = err_in arithmetically shifted right by MU_SHIFT (rounding toward minus infinity). Both x_i and s are two's-complement values.
- R3: Inputs accepted on clock edge k change `wts_out` on edge k+2 and not earlier. `wts_out` keeps its old value after edge k and after edge k+1.
- R4: A sample presented with `upd_en` low leaves every coefficient unchanged.
- R5: A sum above 2^(DW-1)-1 is clamped to 2^(DW-1)-1 and does not wrap.
- R6: A sum below -2^(DW-1) is clamped to -2^(DW-1) and does not wrap.
- R7: A negative sample is multiplied correctly. Its top two bits form a signed digit with values 0, +1, -2, -1.
- R8: Updates accepted on consecutive edges all take effect in order. Each update builds on the coefficient that the previous update wrote.
- R9: Lane i uses only tap i, which is bits [i*DW +: DW] of `taps_in`. Its coefficient is bits [i*DW +: DW] of `wts_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, to be released away from the rising edge |
| upd_en | input | 1 | Accept the current error and taps as one update |
| err_in | input | DW | Delayed error value, two's complement |
| taps_in | input | N_TAPS*DW | Delayed input samples, lane i in bits [i*DW +: DW] |
| wts_out | output | N_TAPS*DW | Current coefficients, lane i in bits [i*DW +: DW] |

## Verification
Two operations can fall in the same cycle. One is the final addition of an update. The other is the write of the previous update, whose result that addition must read back. The bench provokes this by streaming updates on back-to-back edges, with some idle gaps, while the coefficients sit near the rails. Each clamped sum then lands on a coefficient that was itself just written. A bench model applies each update three negative edges after it was driven and compares all lanes on every cycle. Any lost or doubled write, and any wrapped result, shows as a mismatch.

// File: rtl/dlms_pkg.sv
package dlms_pkg;

  // Two-bit radix-4 digit of a sample
  typedef enum logic [1:0] {
    DIG_ZERO  = 2'b00,
    DIG_ONE   = 2'b01,
    DIG_TWO   = 2'b10,
    DIG_THREE = 2'b11
  } dig_e;

endpackage

// File: rtl/dlms_ppg.sv
module dlms_ppg
  import dlms_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0]              x_in,
  input  logic [DW+1:0]              m1,
  input  logic [DW+1:0]              m2,
  input  logic [DW+1:0]              m3,
  input  logic [DW+1:0]              mn1,
  input  logic [DW+1:0]              mn2,
  output logic [(DW/2)*(DW+2)-1:0]   pp_flat
);

  localparam int NDIG = DW / 2;
  localparam int PW   = DW + 2;

  for (genvar k = 0; k < NDIG; k++) begin : g_dig
    logic [1:0] dg;
    assign dg = x_in[2*k +: 2];

    if (k == NDIG - 1) begin : g_top
      // signed top digit: 0, +1, -2, -1
      always_comb begin
        case (dig_e'(dg))
          DIG_ONE:   pp_flat[k*PW +: PW] = m1;
          DIG_TWO:   pp_flat[k*PW +: PW] = mn2;
          DIG_THREE: pp_flat[k*PW +: PW] = mn1;
          default:   pp_flat[k*PW +: PW] = '0;
        endcase
      end
    end else begin : g_low
      always_comb begin
        case (dig_e'(dg))
          DIG_ONE:   pp_flat[k*PW +: PW] = m1;
          DIG_TWO:   pp_flat[k*PW +: PW] = m2;
          DIG_THREE: pp_flat[k*PW +: PW] = m3;
          default:   pp_flat[k*PW +: PW] = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/dlms_mac_lane.sv
module dlms_mac_lane #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          v1,
  input  logic          v2,
  input  logic [DW-1:0] x_in,
  input  logic [DW+1:0] m1,
  input  logic [DW+1:0] m2,
  input  logic [DW+1:0] m3,
  input  logic [DW+1:0] mn1,
  input  logic [DW+1:0] mn2,
  output logic [DW-1:0] w_out
);

  localparam int NDIG = DW / 2;
  localparam int PW   = DW + 2;
  localparam int PRW  = 2 * DW;
  localparam int HALF = NDIG / 2;
  localparam logic signed [PRW:0] WMAX = (PRW+1)'((2 ** (DW-1)) - 1);
  localparam logic signed [PRW:0] WMIN = (PRW+1)'(-(2 ** (DW-1)));

  logic [NDIG*PW-1:0] pp_flat;
  logic [PRW-1:0]     lo_d, hi_d, lo_q, hi_q;
  logic [PRW-1:0]     prod;
  logic signed [PRW:0] sum_s;
  logic [DW-1:0]      w_sat, w_d, w_q;

  dlms_ppg #(.DW(DW)) ppg_i (
    .x_in    (x_in),
    .m1      (m1),
    .m2      (m2),
    .m3      (m3),
    .mn1     (mn1),
    .mn2     (mn2),
    .pp_flat (pp_flat)
  );

  // split shift-add tree: lower digits and upper digits
  always_comb begin
    logic [PRW-1:0] ext;
    lo_d = '0;
    hi_d = '0;
    for (int k = 0; k < NDIG; k++) begin
      ext = {{(PRW-PW){pp_flat[k*PW+PW-1]}}, pp_flat[k*PW +: PW]};
      if (k < HALF) lo_d = lo_d + (ext << (2*k));
      else          hi_d = hi_d + (ext << (2*k));
    end
  end

  // final add of the tree, accumulate and clamp
  always_comb begin
    prod  = lo_q + hi_q;
    sum_s = $signed({prod[PRW-1], prod}) +
            $signed({{(PRW+1-DW){w_q[DW-1]}}, w_q});
    if (sum_s > WMAX)      w_sat = WMAX[DW-1:0];
    else if (sum_s < WMIN) w_sat = WMIN[DW-1:0];
    else                   w_sat = sum_s[DW-1:0];
    w_d = v2 ? w_sat : w_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (v1) begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) w_q <= '0;
    else        w_q <= w_d;
  end

  assign w_out = w_q;

  // R4: no accepted update at the accumulator, coefficient holds
  a_r4_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !v2 |=> $stable(w_q));

  // R5: adding a non-negative product never lowers the coefficient
  a_r5_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (v2 && !prod[PRW-1]) |=> ($signed(w_q) >= $signed($past(w_q))));

  // R6: adding a negative product never raises the coefficient
  a_r6_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (v2 && prod[PRW-1]) |=> ($signed(w_q) <= $signed($past(w_q))));

  // R2: a zero scaled error yields a zero product after the tree register
  a_r2_zero_err: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && m1 == '0) |=> (prod == '0));

endmodule

// File: rtl/dlms_wupd_array.sv
module dlms_wupd_array #(
  parameter int N_TAPS   = 8,
  parameter int DW       = 8,
  parameter int MU_SHIFT = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd_en,
  input  logic [DW-1:0]        err_in,
  input  logic [N_TAPS*DW-1:0] taps_in,
  output logic [N_TAPS*DW-1:0] wts_out
);

  localparam int PW = DW + 2;

  logic [N_TAPS*DW-1:0] x_d, x_q;
  logic [DW-1:0]        err_d, err_q;
  logic                 v1_q, v2_q;
  logic signed [DW-1:0] s_err;
  logic [PW-1:0]        m1, m2, m3, mn1, mn2;

  // stage 1: sample register ahead of the partial-product generators
  always_comb begin
    x_d   = upd_en ? taps_in : x_q;
    err_d = upd_en ? err_in  : err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q   <= '0;
      err_q <= '0;
      v1_q  <= 1'b0;
      v2_q  <= 1'b0;
    end else begin
      x_q   <= x_d;
      err_q <= err_d;
      v1_q  <= upd_en;
      v2_q  <= v1_q;
    end
  end

  // step size by shift, multiples shared by all lanes
  always_comb begin
    s_err = $signed(err_q) >>> MU_SHIFT;
    m1    = {{2{s_err[DW-1]}}, s_err};
    m2    = {m1[PW-2:0], 1'b0};
    m3    = m1 + m2;
    mn1   = '0 - m1;
    mn2   = '0 - m2;
  end

  for (genvar i = 0; i < N_TAPS; i++) begin : g_lane
    dlms_mac_lane #(.DW(DW)) lane_i (
      .clk   (clk),
      .rst_n (rst_n),
      .v1    (v1_q),
      .v2    (v2_q),
      .x_in  (x_q[i*DW +: DW]),
      .m1    (m1),
      .m2    (m2),
      .m3    (m3),
      .mn1   (mn1),
      .mn2   (mn2),
      .w_out (wts_out[i*DW +: DW])
    );
  end

endmodule

// File: tb/dlms_wupd_array_tb.sv
`timescale 1ns/1ps
module dlms_wupd_array_tb_top;

  localparam int N  = 8;
  localparam int DW = 8;
  localparam int SH = 2;

  logic           clk;
  logic           rst_n;
  logic           upd_en;
  logic [DW-1:0]  err_in;
  logic [N*DW-1:0] taps_in;
  logic [N*DW-1:0] wts_out;

  int errors = 0;
  int checks = 0;
  int n = 0;
  int model_w [N];
  logic [DW-1:0]   r_err [4];
  logic [N*DW-1:0] r_x   [4];
  logic            r_en  [4];
  string           r_tag [4];

  dlms_wupd_array #(.N_TAPS(N), .DW(DW), .MU_SHIFT(SH)) dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_en  (upd_en),
    .err_in  (err_in),
    .taps_in (taps_in),
    .wts_out (wts_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check_lane(input int i, input int exp, input string tag);
    int act;
    act = int'($signed(wts_out[i*DW +: DW]));
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s lane %0d: actual %0d expected %0d", tag, i, act, exp);
    end
  endtask

  // drive one sample at a negative edge; first retire the one from three edges back
  task automatic step(input logic [DW-1:0] e, input logic [N*DW-1:0] xv,
                      input logic en, input string tag);
    int a, s, xi, raw;
    string t;
    @(negedge clk);
    a = (n + 1) % 4;
    for (int i = 0; i < N; i++) begin
      t = (tag != "") ? tag : "R4";
      if (n >= 3 && r_en[a]) begin
        s   = int'($signed(r_err[a])) >>> SH;
        xi  = int'($signed(r_x[a][i*DW +: DW]));
        raw = model_w[i] + s * xi;
        if (raw > 127)       begin model_w[i] = 127;  t = "R5"; end
        else if (raw < -128) begin model_w[i] = -128; t = "R6"; end
        else begin
          model_w[i] = raw;
          t = (xi < 0) ? "R7" : "R2";
        end
        if (r_tag[a] != "") t = r_tag[a];
      end
      check_lane(i, model_w[i], t);
    end
    upd_en  = en;
    err_in  = e;
    taps_in = xv;
    r_err[n % 4] = e;
    r_x[n % 4]   = xv;
    r_en[n % 4]  = en;
    r_tag[n % 4] = tag;
    n++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n  = 1'b0;
    upd_en = 1'b0;
    #2;
    for (int i = 0; i < N; i++) begin
      model_w[i] = 0;
      check_lane(i, 0, "R1");
    end
    @(negedge clk);
    for (int i = 0; i < N; i++) check_lane(i, 0, "R1");
    rst_n = 1'b1;
    n = 0;
    for (int j = 0; j < 4; j++) r_en[j] = 1'b0;
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [N*DW-1:0] xv;
    rst_n = 1'b0; upd_en = 1'b0; err_in = '0; taps_in = '0;
    do_reset();

    // R3: single update, weights hold for two edges then change
    step(8'd16, {N{8'd3}}, 1'b1, "R3");
    for (int k = 0; k < 4; k++) step('0, '0, 1'b0, "R3");

    // sweep of every error value, mixed enables
    for (int c = 0; c < 256; c++) begin
      for (int i = 0; i < N; i++) xv[i*DW +: DW] = 8'(c*13 + i*71 + 9);
      step(8'(c), xv, (c % 7) != 3, "");
    end

    // small values for fine accumulation and R4 gaps
    for (int c = 0; c < 200; c++) begin
      for (int i = 0; i < N; i++) xv[i*DW +: DW] = 8'((c*3 + i*5) % 9 - 4);
      step(8'((c % 16) - 8), xv, (c % 5) != 2, "");
    end

    // R8: back-to-back updates
    do_reset();
    for (int c = 0; c < 10; c++) begin
      for (int i = 0; i < N; i++) xv[i*DW +: DW] = 8'(i - 3);
      step(8'd4, xv, 1'b1, "R8");
    end
    for (int k = 0; k < 4; k++) step('0, '0, 1'b0, "R8");

    // R9: one tap at a time
    do_reset();
    for (int j = 0; j < N; j++) begin
      xv = '0;
      xv[j*DW +: DW] = 8'd5;
      step(8'd20, xv, 1'b1, "R9");
      for (int k = 0; k < 3; k++) step('0, '0, 1'b0, "R9");
    end

    // extremes: R5 and R6 rails with the most negative sample (R7)
    step(8'h80, {N{8'h80}}, 1'b1, "");
    step(8'h7f, {N{8'h80}}, 1'b1, "");
    step(8'h80, {N{8'h80}}, 1'b1, "");
    for (int k = 0; k < 4; k++) step('0, '0, 1'b0, "");

    // R1: reset in the middle of a stream
    step(8'd40, {N{8'd7}}, 1'b1, "");
    do_reset();
    for (int k = 0; k < 4; k++) step('0, '0, 1'b0, "R1");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule